// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer. Its write side and read side run on separate clocks, which may be unrelated or may be the same clock. A producer stores one word on each write-clock edge while its active-low write enable is held. A consumer moves one word into a registered output on each read-clock edge while its active-low read enable is held. Five active-low status flags report the fill level: empty, full, almost-empty, almost-full and more-than-half-full.

Each side owns a binary pointer that is one bit wider than the address. The pointer is passed to the other side in Gray code through a two-stage synchronizer. Each flag is computed in the domain that uses it, so a flag can be late in reporting an event from the other side, but it never reports a level that is not safe. Two threshold offsets control the almost flags. At reset they take a default that depends on the depth. They are reprogrammed through the write-data lines while an active-low load strobe is held. An active-low output enable produces a separate drive indication in place of a tri-state pad.

Top module: `dcfifo_flags`

## Requirements
- R1: When rstN is low, both pointers return to the first location and the output register clears to zero. The flags then read emptyN=0, aeN=0, fullN=1, afN=1 and halfN=1. Both offsets take their default: 31 for DEPTH up to 256, 63 for DEPTH up to 512, and 127 for larger depths.
- R2: On a wclk rising edge with wrEnN=0, loadN=1 and fullN=1, wrData is stored. Words leave the buffer in the order they were written.
- R3: On an rclk rising edge with rdEnN=0 and emptyN=1, the oldest stored word appears on qOut after that edge. While rdEnN=1, qOut holds its value.
- R4: A write attempted while fullN=0 is ignored. No word is stored and no stored word changes.
- R5: A read attempted while emptyN=0 is ignored, and qOut holds its value.
- R6: fullN is low when the level is DEPTH and is generated on wclk. emptyN is low when the level is zero and is generated on rclk.
- R7: aeN is low when the level is less than or equal to the empty offset.
- R8: afN is low when the level plus the full offset is greater than or equal to DEPTH.
- R9: halfN is low when the level is greater than DEPTH/2.
- R10: On a wclk edge with loadN=0 and wrEnN=0, wrData[11:0] is written to an offset register and no word enters the buffer. The first such edge after reset writes the empty offset, the next writes the full offset, and the target keeps alternating after that.
- R11: qDrive is high exactly when oeN is low.
- R12: After activity stops on both ports, every flag matches the true level within three edges of the clock that owns that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rstN | input | 1 | Asynchronous active-low reset, shared by both domains |
| wrEnN | input | 1 | Active-low write enable |
| loadN | input | 1 | Active-low offset load select |
| wrData | input | 18 | Write data; bits 11:0 also carry offset values |
| rdEnN | input | 1 | Active-low read enable |
| oeN | input | 1 | Active-low output enable |
| qOut | output | 18 | Registered read data |
| qDrive | output | 1 | High while the output should be driven |
| emptyN | output | 1 | Active-low empty flag (rclk domain) |
| fullN | output | 1 | Active-low full flag (wclk domain) |
| aeN | output | 1 | Active-low almost-empty flag (rclk domain) |
| afN | output | 1 | Active-low almost-full flag (wclk domain) |
| halfN | output | 1 | Active-low more-than-half-full flag (rclk domain) |

## Verification
The checker covers the rules that hold on every cycle. The write address never moves while full. The output register never changes on an empty or idle read edge. The write address advances by at most one per edge. Full always implies almost-full, and empty always implies almost-empty. Only the bench scenarios can show the rest, because each depends on a history of words. That covers data ordering through the memory, the exact level at which each threshold flag switches after settling, the alternating target of the offset loads, and the fact that a write refused at full leaves no trace in the words read back later.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;   // store wrData at the write address (wclk)
    logic pop;    // load the output register from the read address (rclk)
  } fifoStb_t;

  // Depth-dependent default for both threshold offsets
  function automatic int defaultOffset(input int depth);
    if (depth <= 256) return 31;
    else if (depth <= 512) return 63;
    else return 127;
  endfunction

endpackage

// File: rtl/dcfifo_gsync.sv
module dcfifo_gsync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/dcfifo_loader.sv
module dcfifo_loader
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int OFS_W = 12
) (
  input  logic             wclk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic             wrEnN,
  input  logic [OFS_W-1:0] ofsIn,
  output logic [OFS_W-1:0] emptyOfs,
  output logic [OFS_W-1:0] fullOfs
);
  localparam logic [OFS_W-1:0] DFLT = OFS_W'(defaultOffset(DEPTH));

  logic toFull;

  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN) begin
      emptyOfs <= DFLT;
      fullOfs  <= DFLT;
      toFull   <= 1'b0;
    end else if (!loadN && !wrEnN) begin
      if (toFull) fullOfs  <= ofsIn;
      else        emptyOfs <= ofsIn;
      toFull <= ~toFull;
    end
  end
endmodule

// File: rtl/dcfifo_ctl.sv
module dcfifo_ctl
  import dcfifo_pkg::*;
#(
  parameter  int DEPTH  = 256,
  parameter  int OFS_W  = 12,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PW     = ADDR_W + 1
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              loadN,
  input  logic              rdEnN,
  input  logic [OFS_W-1:0]  emptyOfs,
  input  logic [OFS_W-1:0]  fullOfs,
  output fifoStb_t          stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullN,
  output logic              afN,
  output logic              emptyN,
  output logic              aeN,
  output logic              halfN
);
  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, wrBinNxt, rdGraySyn, wrLevel;
  logic          isFull, pushC;
  logic [31:0]   wrLevel32;

  dcfifo_gsync #(.W(PW)) rdToWr_i (
    .clk(wclk), .rstN(rstN), .din(rdGray), .dout(rdGraySyn)
  );

  always_comb begin
    isFull    = (wrGray == {~rdGraySyn[PW-1:PW-2], rdGraySyn[PW-3:0]});
    pushC     = ~wrEnN & loadN & ~isFull;
    wrBinNxt  = wrBin + PW'(pushC);
    wrLevel   = wrBin - fromGray(rdGraySyn);
    wrLevel32 = 32'(wrLevel);
  end

  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNxt;
      wrGray <= toGray(wrBinNxt);
    end
  end

  assign fullN = ~isFull;
  assign afN   = ~((wrLevel32 + 32'(fullOfs)) >= 32'(DEPTH));

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdGray, rdBinNxt, wrGraySyn, rdLevel;
  logic          isEmpty, popC;
  logic [31:0]   rdLevel32;

  dcfifo_gsync #(.W(PW)) wrToRd_i (
    .clk(rclk), .rstN(rstN), .din(wrGray), .dout(wrGraySyn)
  );

  always_comb begin
    isEmpty   = (rdGray == wrGraySyn);
    popC      = ~rdEnN & ~isEmpty;
    rdBinNxt  = rdBin + PW'(popC);
    rdLevel   = fromGray(wrGraySyn) - rdBin;
    rdLevel32 = 32'(rdLevel);
  end

  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else begin
      rdBin  <= rdBinNxt;
      rdGray <= toGray(rdBinNxt);
    end
  end

  assign emptyN = ~isEmpty;
  assign aeN    = ~(rdLevel32 <= 32'(emptyOfs));
  assign halfN  = ~(rdLevel32 > 32'(DEPTH / 2));

  // ---------------- strobes to datapath ----------------
  assign stb.push = pushC;
  assign stb.pop  = popC;
  assign wrAddr   = wrBin[ADDR_W-1:0];
  assign rdAddr   = rdBin[ADDR_W-1:0];
endmodule

// File: rtl/dcfifo_dp.sv
module dcfifo_dp
  import dcfifo_pkg::*;
#(
  parameter  int DATA_W = 18,
  parameter  int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              oeN,
  output logic [DATA_W-1:0] qOut,
  output logic              qDrive
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (stb.push) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN)        qOut <= '0;
    else if (stb.pop) qOut <= store[rdAddr];
  end

  assign qDrive = ~oeN;
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
  import dcfifo_pkg::*;
#(
  parameter  int DATA_W = 18,
  parameter  int DEPTH  = 256,
  parameter  int OFS_W  = 12,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rstN,
  input  logic              wrEnN,
  input  logic              loadN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnN,
  input  logic              oeN,
  output logic [DATA_W-1:0] qOut,
  output logic              qDrive,
  output logic              emptyN,
  output logic              fullN,
  output logic              aeN,
  output logic              afN,
  output logic              halfN
);
  fifoStb_t          stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [OFS_W-1:0]  emptyOfs, fullOfs;

  dcfifo_loader #(.DEPTH(DEPTH), .OFS_W(OFS_W)) ldr_i (
    .wclk(wclk), .rstN(rstN), .loadN(loadN), .wrEnN(wrEnN),
    .ofsIn(wrData[OFS_W-1:0]), .emptyOfs(emptyOfs), .fullOfs(fullOfs)
  );

  dcfifo_ctl #(.DEPTH(DEPTH), .OFS_W(OFS_W)) ctl_i (
    .wclk(wclk), .rclk(rclk), .rstN(rstN),
    .wrEnN(wrEnN), .loadN(loadN), .rdEnN(rdEnN),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .afN(afN), .emptyN(emptyN), .aeN(aeN), .halfN(halfN)
  );

  dcfifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .wclk(wclk), .rclk(rclk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .oeN(oeN), .qOut(qOut), .qDrive(qDrive)
  );
endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rstN,
  input logic              rdEnN,
  input logic              fullN,
  input logic              emptyN,
  input logic              aeN,
  input logic              afN,
  input logic [DATA_W-1:0] qOut,
  input logic [ADDR_W-1:0] wrAddr
);
  // R4: no write address movement on an edge where full was flagged
  a_r4_no_push_full: assert property (@(posedge wclk) disable iff (!rstN)
    !fullN |=> wrAddr == $past(wrAddr));

  // R2: the write address advances by at most one location per edge
  a_r2_addr_step: assert property (@(posedge wclk) disable iff (!rstN)
    ADDR_W'(wrAddr - $past(wrAddr)) <= ADDR_W'(1));

  // R5: output register frozen on an edge seen as empty
  a_r5_hold_empty: assert property (@(posedge rclk) disable iff (!rstN)
    !emptyN |=> $stable(qOut));

  // R3: output register frozen while read enable is inactive
  a_r3_hold_idle: assert property (@(posedge rclk) disable iff (!rstN)
    rdEnN |=> $stable(qOut));

  // R7: an empty buffer is always also almost-empty
  a_r7_empty_is_ae: assert property (@(posedge rclk) disable iff (!rstN)
    !emptyN |-> !aeN);

  // R8: a full buffer is always also almost-full
  a_r8_full_is_af: assert property (@(posedge wclk) disable iff (!rstN)
    !fullN |-> !afN);
endmodule

bind dcfifo_flags dcfifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .wclk(wclk), .rclk(rclk), .rstN(rstN), .rdEnN(rdEnN),
  .fullN(fullN), .emptyN(emptyN), .aeN(aeN), .afN(afN),
  .qOut(qOut), .wrAddr(wrAddr)
);

// File: tb/dcfifo_flags_tb_top.sv
module dcfifo_flags_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DATA_W = 18;
  localparam int DEPTH = 256;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rstN, wrEnN, loadN, rdEnN, oeN;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] qOut;
  logic qDrive, emptyN, fullN, aeN, afN, halfN;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dcfifo_flags #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .wclk(wclk), .rclk(rclk), .rstN(rstN), .wrEnN(wrEnN), .loadN(loadN),
    .wrData(wrData), .rdEnN(rdEnN), .oeN(oeN), .qOut(qOut), .qDrive(qDrive),
    .emptyN(emptyN), .fullN(fullN), .aeN(aeN), .afN(afN), .halfN(halfN)
  );

  int nChk = 0, nBad = 0;
  int eOfs = 31, fOfs = 31;
  logic [DATA_W-1:0] model[$];
  logic rdPend = 1'b0;
  logic [DATA_W-1:0] rdExp;
  logic done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected flag levels (active-low), from the requirements
  function automatic int expEmptyN(int lvl); return (lvl != 0) ? 1 : 0; endfunction
  function automatic int expFullN(int lvl);  return (lvl != DEPTH) ? 1 : 0; endfunction
  function automatic int expAeN(int lvl);    return (lvl <= eOfs) ? 0 : 1; endfunction
  function automatic int expAfN(int lvl);    return (lvl + fOfs >= DEPTH) ? 0 : 1; endfunction
  function automatic int expHalfN(int lvl);  return (lvl > DEPTH/2) ? 0 : 1; endfunction

  task automatic checkFlags(input string where);
    int lvl;
    lvl = model.size();
    chk({"R6 emptyN ", where}, int'(emptyN), expEmptyN(lvl));
    chk({"R6 fullN ", where},  int'(fullN),  expFullN(lvl));
    chk({"R7 aeN ", where},    int'(aeN),    expAeN(lvl));
    chk({"R8 afN ", where},    int'(afN),    expAfN(lvl));
    chk({"R9 halfN ", where},  int'(halfN),  expHalfN(lvl));
  endtask

  // R12: flags compared only after both domains have idled
  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  task automatic wrCycle(input bit en);
    @(negedge wclk);
    wrEnN = ~en;
    wrData = DATA_W'($urandom);
    #1;
    if (en && fullN) model.push_back(wrData);
  endtask

  task automatic rdCycle(input bit en);
    @(negedge rclk);
    if (rdPend) chk("R3 R2 read data", int'(qOut), int'(rdExp));
    rdPend = 1'b0;
    rdEnN = ~en;
    #1;
    if (en && emptyN) begin
      rdExp = model.pop_front();
      rdPend = 1'b1;
    end
  endtask

  task automatic fillTo(input int n);
    while (model.size() < n) wrCycle(1'b1);
    wrCycle(1'b0);
  endtask

  task automatic drainTo(input int n);
    while (model.size() > n) rdCycle(1'b1);
    rdCycle(1'b0);
    rdCycle(1'b0);
  endtask

  task automatic levelCheck(input int n, input string where);
    if (model.size() < n) fillTo(n); else drainTo(n);
    settle();
    checkFlags(where);
  endtask

  initial begin
    logic [DATA_W-1:0] held;
    void'($urandom(32'd2024));
    rstN = 1'b0; wrEnN = 1'b1; loadN = 1'b1; rdEnN = 1'b1; oeN = 1'b1;
    wrData = '0;
    repeat (3) @(negedge wclk);
    // R1 reset state, sampled while reset is held
    chk("R1 qOut reset", int'(qOut), 0);
    checkFlags("R1 reset");
    chk("R11 qDrive oeN=1", int'(qDrive), 0);
    oeN = 1'b0; #1;
    chk("R11 qDrive oeN=0", int'(qDrive), 1);
    @(negedge wclk); rstN = 1'b1;
    settle();
    checkFlags("R1 after release");

    // single word in and out
    levelCheck(1, "level 1");
    levelCheck(0, "level 0");

    // R5: read attempted while empty leaves qOut alone
    held = qOut;
    rdCycle(1'b1); rdCycle(1'b0); rdCycle(1'b0);
    chk("R5 qOut hold on empty", int'(qOut), int'(held));

    // R7 R9 R8 boundaries with default offsets (31)
    levelCheck(31, "R7 lvl31");
    levelCheck(32, "R7 lvl32");
    levelCheck(128, "R9 lvl128");
    levelCheck(129, "R9 lvl129");
    levelCheck(224, "R8 lvl224");
    levelCheck(225, "R8 lvl225");
    levelCheck(DEPTH, "R6 full");

    // R4: writes refused while full
    for (int i = 0; i < 3; i++) begin
      wrCycle(1'b1);
      chk("R4 fullN during write attempt", int'(fullN), 0);
    end
    wrCycle(1'b0);
    settle();
    checkFlags("R4 still full");
    levelCheck(0, "R4 drained");

    // R10: two loads, empty offset then full offset, nothing stored
    @(negedge wclk); loadN = 1'b0; wrEnN = 1'b0; wrData = DATA_W'(5);
    @(negedge wclk); wrData = DATA_W'(10);
    @(negedge wclk); loadN = 1'b1; wrEnN = 1'b1;
    eOfs = 5; fOfs = 10;
    settle();
    checkFlags("R10 after load");
    levelCheck(5, "R10 R7 lvl5");
    levelCheck(6, "R10 R7 lvl6");
    levelCheck(245, "R10 R8 lvl245");
    levelCheck(246, "R10 R8 lvl246");
    levelCheck(0, "R10 drained");

    // random traffic: write-heavy, then read-heavy
    fork
      begin for (int i = 0; i < 1200; i++) wrCycle(($urandom % 4) != 0); wrCycle(1'b0); end
      begin for (int i = 0; i < 850; i++) rdCycle(($urandom % 4) == 0); rdCycle(1'b0); end
    join
    settle();
    checkFlags("random phase 1");
    fork
      begin for (int i = 0; i < 1200; i++) wrCycle(($urandom % 4) == 0); wrCycle(1'b0); end
      begin for (int i = 0; i < 850; i++) rdCycle(($urandom % 4) != 0); rdCycle(1'b0); end
    join
    settle();
    checkFlags("random phase 2");
    levelCheck(0, "final drain");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule